// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor core that uses overlapping register windows. Software addresses 32 registers through 5-bit numbers. Numbers 0 to 7 select globals that every window shares. Numbers 8 to 31 select 24 registers that belong to the window named by the current window pointer. A subroutine call moves the pointer down one window. The caller's outgoing-argument registers then reappear as the callee's incoming-argument registers, so arguments and the return address pass between routines without any memory traffic.

The block has two combinational read ports and one write port. It also takes a 3-bit window command that can save, restore, enter a trap or return from a trap. A mask register, loaded through its own port, marks windows that hold no live data. A save that would land on a marked window raises an overflow request. A restore or trap return that would land on a marked window raises an underflow request. In both cases the pointer stays where it is. The spill and fill handlers that respond to these requests are outside the block.

Top module: `win_regfile`

## Requirements
- R1: After reset the window pointer is 0, the mask is all zeros, and neither trap request is asserted.
- R2: Register number 0 always reads as zero, and writes to it change nothing.
- R3: Numbers 1 to 7 select one set of globals that is shared by every window.
- R4: Within a window, numbers 8–15 are the outgoing registers, 16–23 are the locals and 24–31 are the incoming registers. Outgoing register k of window w is the same storage as incoming register k of window w−1 (mod NWIN). The locals and incoming registers are private to each window.
- R5: Command 1 (save) moves the pointer to w−1 mod NWIN. If the mask bit of that target window is set, the block instead asserts `trap_ovf` in the same cycle and keeps the pointer unchanged.
- R6: Command 2 (restore) moves the pointer to w+1 mod NWIN. If the mask bit of that target window is set, the block instead asserts `trap_unf` and keeps the pointer unchanged. The two trap requests are never asserted together.
- R7: Command 3 (trap entry) always moves the pointer to w−1 mod NWIN, whatever the mask holds, and raises no request.
- R8: Command 4 (trap return) behaves like restore: it moves the pointer to w+1 mod NWIN, or asserts `trap_unf` and holds the pointer if the target window is masked. Commands 0, 5, 6 and 7 leave the pointer unchanged.
- R9: When a read port names the same nonzero register that is being written in that cycle, it returns the write data (write-first bypass).
- R10: When `wim_we` is high, `wim_wdata` is loaded into the mask at the clock edge and appears on `wim` in the next cycle.
- R11: A write that arrives in the same cycle as a window command goes into the window that was current before the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 5 | Register number for read port A |
| rd_a_data | output | XLEN | Read data from port A (combinational) |
| rd_b_idx | input | 5 | Register number for read port B |
| rd_b_data | output | XLEN | Read data from port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Register number for the write |
| wr_data | input | XLEN | Write data |
| win_cmd | input | 3 | Window command: 0 none, 1 save, 2 restore, 3 trap entry, 4 trap return |
| wim_we | input | 1 | Load enable for the mask |
| wim_wdata | input | NWIN | New mask value |
| cwp | output | $clog2(NWIN) | Current window pointer |
| wim | output | NWIN | Current mask |
| trap_ovf | output | 1 | Overflow trap request (combinational) |
| trap_unf | output | 1 | Underflow trap request (combinational) |

## Verification
The bench builds the block with its default values, NWIN=7 and XLEN=32. Seven is not a power of two, so the pointer has to wrap explicitly at both ends, between 0 and 6. A random sequence of saves and restores crosses that seam many times. With seven windows, a mask holding only one or two bits still triggers overflow and underflow often, and both read ports see every window's outgoing registers aliased onto its neighbour's incoming registers within a few thousand cycles.

// File: rtl/win_regfile.sv
module win_regfile #(
  parameter int NWIN = 7,
  parameter int XLEN = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [4:0]              rd_a_idx,
  output logic [XLEN-1:0]         rd_a_data,
  input  logic [4:0]              rd_b_idx,
  output logic [XLEN-1:0]         rd_b_data,
  input  logic                    wr_en,
  input  logic [4:0]              wr_idx,
  input  logic [XLEN-1:0]         wr_data,
  input  logic [2:0]              win_cmd,
  input  logic                    wim_we,
  input  logic [NWIN-1:0]         wim_wdata,
  output logic [$clog2(NWIN)-1:0] cwp,
  output logic [NWIN-1:0]         wim,
  output logic                    trap_ovf,
  output logic                    trap_unf
);
  localparam int CW = $clog2(NWIN);
  localparam int PW = CW + 4;
  localparam logic [CW-1:0] LAST = CW'(NWIN - 1);
  localparam logic [2:0] C_SAVE = 3'd1, C_REST = 3'd2, C_TENT = 3'd3, C_TRET = 3'd4;

  logic [CW-1:0]   cwp_q, cwp_dn, cwp_up;
  logic [NWIN-1:0] wim_q;
  logic [XLEN-1:0] glb [8];
  logic [XLEN-1:0] win [NWIN*16];

  assign cwp_dn = (cwp_q == '0) ? LAST : cwp_q - 1'b1;
  assign cwp_up = (cwp_q == LAST) ? '0 : cwp_q + 1'b1;

  assign trap_ovf = (win_cmd == C_SAVE) && wim_q[cwp_dn];
  assign trap_unf = ((win_cmd == C_REST) || (win_cmd == C_TRET)) && wim_q[cwp_up];

  assign cwp = cwp_q;
  assign wim = wim_q;

  function automatic logic [PW-1:0] phys(input logic [4:0] idx);
    case (idx[4:3])
      2'd1:    phys = {cwp_dn, 1'b1, idx[2:0]};
      2'd2:    phys = {cwp_q, 1'b0, idx[2:0]};
      2'd3:    phys = {cwp_q, 1'b1, idx[2:0]};
      default: phys = '0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] rd(input logic [4:0] idx);
    if (idx == 5'd0)                   rd = '0;
    else if (wr_en && wr_idx == idx)   rd = wr_data;
    else if (idx[4:3] == 2'd0)         rd = glb[idx[2:0]];
    else                               rd = win[phys(idx)];
  endfunction

  assign rd_a_data = rd(rd_a_idx);
  assign rd_b_data = rd(rd_b_idx);

  always_ff @(posedge clk) begin
    if (wr_en && wr_idx != 5'd0) begin
      if (wr_idx[4:3] == 2'd0) glb[wr_idx[2:0]] <= wr_data;
      else                     win[phys(wr_idx)] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp_q <= '0;
      wim_q <= '0;
    end else begin
      if (wim_we) wim_q <= wim_wdata;
      case (win_cmd)
        C_SAVE:         if (!trap_ovf) cwp_q <= cwp_dn;
        C_TENT:         cwp_q <= cwp_dn;
        C_REST, C_TRET: if (!trap_unf) cwp_q <= cwp_up;
        default:        cwp_q <= cwp_q;
      endcase
    end
  end
endmodule

// File: rtl/win_regfile_chk.sv
module win_regfile_chk #(
  parameter int NWIN = 7,
  parameter int XLEN = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [4:0]              rd_a_idx,
  input logic [XLEN-1:0]         rd_a_data,
  input logic                    wr_en,
  input logic [4:0]              wr_idx,
  input logic [XLEN-1:0]         wr_data,
  input logic [2:0]              win_cmd,
  input logic                    wim_we,
  input logic [NWIN-1:0]         wim_wdata,
  input logic [$clog2(NWIN)-1:0] cwp,
  input logic [NWIN-1:0]         wim,
  input logic                    trap_ovf,
  input logic                    trap_unf
);
  localparam int CW = $clog2(NWIN);
  localparam logic [CW-1:0] LAST = CW'(NWIN - 1);

  assert_g0_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_idx == 5'd0 |-> rd_a_data == '0);

  assert_ovf_only_on_save_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_ovf |-> win_cmd == 3'd1);

  assert_ovf_holds_cwp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trap_ovf |=> $stable(cwp));

  assert_unf_holds_cwp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_unf |=> $stable(cwp));

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_ovf, trap_unf}));

  assert_restore_moves_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_cmd == 3'd2 && !trap_unf) |=>
      cwp == (($past(cwp) == LAST) ? '0 : $past(cwp) + 1'b1));

  assert_trap_entry_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_cmd == 3'd3 |=> cwp == (($past(cwp) == '0) ? LAST : $past(cwp) - 1'b1));

  assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == rd_a_idx && wr_idx != 5'd0) |-> rd_a_data == wr_data);

  assert_wim_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wim_we |=> wim == $past(wim_wdata));
endmodule

bind win_regfile win_regfile_chk #(.NWIN(NWIN), .XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .win_cmd(win_cmd),
  .wim_we(wim_we), .wim_wdata(wim_wdata), .cwp(cwp), .wim(wim),
  .trap_ovf(trap_ovf), .trap_unf(trap_unf)
);

// File: tb/win_regfile_test.sv
module win_regfile_test;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 7;
  localparam int XL = 32;
  localparam int CW = $clog2(NW);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] ra = '0, rb = '0, wi = '0;
  logic [XL-1:0] wd = '0;
  logic we = 1'b0, mwe = 1'b0;
  logic [2:0] cmd = '0;
  logic [NW-1:0] mwd = '0;
  logic [XL-1:0] rda, rdb;
  logic [CW-1:0] cwp;
  logic [NW-1:0] wim;
  logic tovf, tunf;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [XL-1:0] mg [8];
  logic [XL-1:0] ml [NW][8];
  logic [XL-1:0] mi [NW][8];
  int mcwp = 0;
  logic [NW-1:0] mwim = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  win_regfile #(.NWIN(NW), .XLEN(XL)) uut (
    .clk(clk), .rst_n(rst_n), .rd_a_idx(ra), .rd_a_data(rda), .rd_b_idx(rb), .rd_b_data(rdb),
    .wr_en(we), .wr_idx(wi), .wr_data(wd), .win_cmd(cmd), .wim_we(mwe), .wim_wdata(mwd),
    .cwp(cwp), .wim(wim), .trap_ovf(tovf), .trap_unf(tunf));

  function automatic int below(int w); return (w + NW - 1) % NW; endfunction
  function automatic int above(int w); return (w + 1) % NW; endfunction

  function automatic logic [XL-1:0] exp_rd(logic [4:0] idx);
    int k = int'(idx[2:0]);
    if (idx == 0) return '0;
    if (we && wi == idx) return wd;
    if (idx < 8)  return mg[k];
    if (idx < 16) return mi[below(mcwp)][k];
    if (idx < 24) return ml[mcwp][k];
    return mi[mcwp][k];
  endfunction

  function automatic string rtag(logic [4:0] idx);
    if (idx == 0) return "R2";
    if (we && wi == idx) return "R9";
    if (idx < 8) return "R3";
    return "R4";
  endfunction

  task automatic chk(string tag, logic [XL-1:0] act, logic [XL-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic [4:0] a, logic [4:0] b, logic w, logic [4:0] widx,
                     logic [XL-1:0] wdat, logic [2:0] c, logic m, logic [NW-1:0] mdat);
    logic eo, eu;
    string ctag;
    ra = a; rb = b; we = w; wi = widx; wd = wdat; cmd = c; mwe = m; mwd = mdat;
    #1;
    eo = (c == 3'd1) && mwim[below(mcwp)];
    eu = (c == 3'd2 || c == 3'd4) && mwim[above(mcwp)];
    ctag = (c == 3'd1) ? "R5" : (c == 3'd4) ? "R8" : "R6";
    chk(rtag(a), rda, exp_rd(a));
    chk(rtag(b), rdb, exp_rd(b));
    chk({ctag, " ovf"}, XL'(tovf), XL'(eo));
    chk({ctag, " unf"}, XL'(tunf), XL'(eu));
    chk("R10 wim", XL'(wim), XL'(mwim));
    @(posedge clk);
    if (w && widx != 0) begin   // R11: lands in the window current before the command
      int k = int'(widx[2:0]);
      if (widx < 8) mg[k] = wdat;
      else if (widx < 16) mi[below(mcwp)][k] = wdat;
      else if (widx < 24) ml[mcwp][k] = wdat;
      else mi[mcwp][k] = wdat;
    end
    if (m) mwim = mdat;
    case (c)
      3'd1: if (!eo) mcwp = below(mcwp);
      3'd3: mcwp = below(mcwp);
      3'd2, 3'd4: if (!eu) mcwp = above(mcwp);
      default: ;
    endcase
    @(negedge clk);
    chk((c == 3'd3) ? "R7 cwp" : "R5 cwp", XL'(cwp), XL'(mcwp));
    we = 1'b0; mwe = 1'b0; cmd = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 cwp", XL'(cwp), '0);
    chk("R1 wim", XL'(wim), '0);
    chk("R1 ovf", XL'(tovf), '0);
    chk("R1 unf", XL'(tunf), '0);
    @(negedge clk);

    for (int w = 0; w < NW; w++) begin
      for (int r = 1; r < 32; r++) cyc(5'(r), 5'(r), 1'b1, 5'(r), $urandom, 3'd0, 1'b0, '0);
      cyc(5'd1, 5'd9, 1'b0, '0, '0, 3'd3, 1'b0, '0);
    end

    // R2: write to register 0 is dropped
    cyc(5'd0, 5'd0, 1'b1, 5'd0, 32'hDEAD_BEEF, 3'd0, 1'b0, '0);
    cyc(5'd0, 5'd1, 1'b0, '0, '0, 3'd0, 1'b0, '0);
    // R4: return address in outgoing 7 seen as incoming 7 after save
    cyc(5'd15, 5'd0, 1'b1, 5'd15, 32'h1234_5678, 3'd0, 1'b0, '0);
    cyc(5'd15, 5'd31, 1'b0, '0, '0, 3'd1, 1'b0, '0);
    cyc(5'd31, 5'd16, 1'b0, '0, '0, 3'd0, 1'b0, '0);
    // R5: overflow on masked target
    cyc(5'd1, 5'd2, 1'b0, '0, '0, 3'd0, 1'b1, NW'(1) << below(mcwp));
    cyc(5'd8, 5'd24, 1'b0, '0, '0, 3'd1, 1'b0, '0);
    // R7: trap entry ignores mask
    cyc(5'd8, 5'd24, 1'b0, '0, '0, 3'd3, 1'b0, '0);
    // R6 / R8: underflow on masked target
    cyc(5'd1, 5'd2, 1'b0, '0, '0, 3'd0, 1'b1, NW'(1) << above(mcwp));
    cyc(5'd8, 5'd24, 1'b0, '0, '0, 3'd2, 1'b0, '0);
    cyc(5'd8, 5'd24, 1'b0, '0, '0, 3'd4, 1'b0, '0);
    cyc(5'd1, 5'd2, 1'b0, '0, '0, 3'd0, 1'b1, '0);
    // R9: write-first bypass, R11: write with concurrent save
    cyc(5'd20, 5'd3, 1'b1, 5'd20, 32'hCAFE_0001, 3'd0, 1'b0, '0);
    cyc(5'd3, 5'd3, 1'b1, 5'd3, 32'hCAFE_0002, 3'd0, 1'b0, '0);
    cyc(5'd10, 5'd20, 1'b1, 5'd10, 32'hCAFE_0003, 3'd1, 1'b0, '0);
    cyc(5'd26, 5'd20, 1'b0, '0, '0, 3'd0, 1'b0, '0);
    // R5..R8 wrap: walk around the ring both ways
    for (int i = 0; i < 2 * NW; i++) cyc(5'd8, 5'd24, 1'b0, '0, '0, 3'd1, 1'b0, '0);
    for (int i = 0; i < 2 * NW; i++) cyc(5'd8, 5'd24, 1'b0, '0, '0, 3'd2, 1'b0, '0);

    for (int i = 0; i < 4000; i++) begin
      int p = $urandom_range(0, 15);
      logic [2:0] c = (p < 4) ? 3'd1 : (p < 8) ? 3'd2 : (p == 8) ? 3'd3 :
                      (p == 9) ? 3'd4 : (p == 10) ? 3'($urandom_range(5, 7)) : 3'd0;
      logic m = ($urandom_range(0, 19) == 0);
      logic [NW-1:0] md = NW'($urandom) & NW'($urandom);
      logic [4:0] widx = 5'($urandom);
      logic [4:0] a = ($urandom_range(0, 7) == 0) ? widx : 5'($urandom);
      cyc(a, 5'($urandom), 1'($urandom), widx, $urandom, c, m, md);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule